// File: doc/BRIEF.md
# Set-bit index extraction engine

This block walks a bit string stored in byte-wide memory and compacts the positions of its one bits into a vector element store. A start pulse loads a base address, a signed 32-bit bit index, a signed 32-bit bit count and an initial element pointer. On each pass through its loop the engine either stops or handles one bit. It stops when the element store is full or when no bits remain. Otherwise it reads the selected bit and, if the bit is one, writes the current bit index into the element slot named by the pointer.

The engine is built to be resumed. It samples an interrupt request only at the top of its loop. When it takes the interrupt it stops with the index, count and pointer left exactly where a later start can pick them up. On normal completion it reports a vector count and a two-bit condition code, which together describe how the section ended. A driver runs the engine once per section, feeding the returned index and count back in, until the condition code shows that no bits remain.

Top module: `setbit_scan`

## Requirements
- R1: After reset, `done`, `interrupted`, `busy`, `mem_req` and `wr_en` are low, and `bix_out`, `bcnt_out`, `ep_out`, `vcount_out` and `cc` are zero.
- R2: When the bit count is zero or negative at the top of the loop, no bit is processed. The engine issues no memory read and no element write, and `bix_out` and `bcnt_out` keep their start values.
- R3: The current bit lies at byte address (base + (bit index >>> 3)) mod 2^ADDR_W, where `>>>` is an arithmetic shift that fills with the sign bit. Bit offset k, given by the low three bits of the index, selects data bit 7−k, so offset 0 is the most significant bit.
- R4: When the selected bit is one, `wr_en` pulses with `wr_elem` equal to the element pointer and `wr_value` equal to the current bit index, and the pointer then increments by one.
- R5: Every processed bit adds one to the bit index and subtracts one from the bit count, whether the bit is one or zero. The index wraps silently from 2^31−1 to −2^31.
- R6: When the pointer equals SECT or the count is ≤ 0 at the top of the loop, the engine finishes: `vcount_out` takes the pointer value and `ep_out` is cleared to 0.
- R7: The condition code is 0 when the vector count is 0 and the bit count is 0. It is 1 when the vector count is 0 and the bit count is negative. It is 2 when the vector count equals SECT and the bit count is positive. It is 3 when the vector count is greater than 0 and the bit count is ≤ 0.
- R8: When `intr_req` is high at the top of the loop and the engine is not finishing, it pulses `interrupted` and keeps the index, count and pointer. Restarting with those values gives the same element writes and the same final result as a run with no interrupt.
- R9: A fetched byte is reused while the byte address does not change. Memory is read once for each change of byte address within a run, and the first byte of each run is always read.
- R10: `done` and `interrupted` are single-cycle pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse, sampled while idle |
| base_addr | input | ADDR_W | Byte address of the bit string |
| bix_in | input | 32 | Signed starting bit index |
| bcnt_in | input | 32 | Signed bit count |
| ep_in | input | EW | Starting element pointer (≤ SECT) |
| intr_req | input | 1 | Interrupt request, taken at loop top |
| mem_req | output | 1 | Byte read request, held until valid |
| mem_addr | output | ADDR_W | Byte read address |
| mem_valid | input | 1 | Read data valid |
| mem_data | input | 8 | Read data byte |
| wr_en | output | 1 | Element write strobe |
| wr_elem | output | EW | Element slot number |
| wr_value | output | 32 | Bit index written |
| bix_out | output | 32 | Current bit index |
| bcnt_out | output | 32 | Current bit count |
| ep_out | output | EW | Current element pointer |
| vcount_out | output | EW | Vector count from the last completion |
| cc | output | 2 | Condition code from the last completion |
| done | output | 1 | Completion pulse |
| interrupted | output | 1 | Interruption pulse |
| busy | output | 1 | Engine active |

## Verification
An element write is a combinational strobe. It appears in the same cycle in which the loop handles a one bit out of the cached byte, so the bench captures writes on every rising edge. `done` or `interrupted` rises one edge after the terminating loop-top cycle, and `bix_out`, `bcnt_out`, `ep_out`, `vcount_out` and `cc` take their final values on that same edge. The bench therefore waits at falling edges for the pulse and samples all results in that half cycle, then checks one half cycle later that the pulse has gone. The bench's memory answers two cycles after a request and counts its replies, so the number of reads can be compared with the model's count of byte-address changes.

// File: rtl/setbit_scan.sv
module setbit_scan #(
  parameter int ADDR_W = 24,
  parameter int SECT   = 16,
  localparam int EW    = $clog2(SECT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [31:0]       bix_in,
  input  logic [31:0]       bcnt_in,
  input  logic [EW-1:0]     ep_in,
  input  logic              intr_req,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_valid,
  input  logic [7:0]        mem_data,
  output logic              wr_en,
  output logic [EW-1:0]     wr_elem,
  output logic [31:0]       wr_value,
  output logic [31:0]       bix_out,
  output logic [31:0]       bcnt_out,
  output logic [EW-1:0]     ep_out,
  output logic [EW-1:0]     vcount_out,
  output logic [1:0]        cc,
  output logic              done,
  output logic              interrupted,
  output logic              busy
);
  localparam logic [EW-1:0] FULL = EW'(SECT);

  typedef enum logic [1:0] {S_IDLE, S_TOP, S_WAIT} st_t;
  st_t st;

  logic [ADDR_W-1:0] base_q, cache_a;
  logic [31:0]       bix_q, bcnt_q;
  logic [EW-1:0]     ep_q, vc_q;
  logic [7:0]        cache_q;
  logic              cache_v;
  logic [1:0]        cc_q;
  logic              done_q, intr_q;

  logic [31:0]       shifted;
  logic [ADDR_W-1:0] baddr;
  logic              stop, hit, step, bitv;
  logic [1:0]        cc_next;

  assign shifted = $signed(bix_q) >>> 3;
  assign baddr   = base_q + shifted[ADDR_W-1:0];
  assign stop    = (ep_q == FULL) || ($signed(bcnt_q) <= 0);
  assign hit     = cache_v && (cache_a == baddr);
  assign bitv    = cache_q[3'd7 - bix_q[2:0]];
  assign step    = (st == S_TOP) && !stop && !intr_req && hit;

  always_comb begin
    if (ep_q == '0)                            cc_next = (bcnt_q == '0) ? 2'd0 : 2'd1;
    else if (ep_q == FULL && !bcnt_q[31] && bcnt_q != '0) cc_next = 2'd2;
    else                                       cc_next = 2'd3;
  end

  assign mem_req     = (st == S_WAIT);
  assign mem_addr    = baddr;
  assign wr_en       = step && bitv;
  assign wr_elem     = ep_q;
  assign wr_value    = bix_q;
  assign bix_out     = bix_q;
  assign bcnt_out    = bcnt_q;
  assign ep_out      = ep_q;
  assign vcount_out  = vc_q;
  assign cc          = cc_q;
  assign done        = done_q;
  assign interrupted = intr_q;
  assign busy        = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      base_q <= '0; cache_a <= '0; cache_q <= '0; cache_v <= 1'b0;
      bix_q <= '0; bcnt_q <= '0; ep_q <= '0; vc_q <= '0; cc_q <= '0;
      done_q <= 1'b0; intr_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      intr_q <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          base_q  <= base_addr;
          bix_q   <= bix_in;
          bcnt_q  <= bcnt_in;
          ep_q    <= ep_in;
          cache_v <= 1'b0;
          st      <= S_TOP;
        end
        S_TOP: begin
          if (stop) begin
            vc_q   <= ep_q;
            cc_q   <= cc_next;
            ep_q   <= '0;
            done_q <= 1'b1;
            st     <= S_IDLE;
          end else if (intr_req) begin
            intr_q <= 1'b1;
            st     <= S_IDLE;
          end else if (hit) begin
            if (bitv) ep_q <= ep_q + 1'b1;
            bix_q  <= bix_q + 32'd1;
            bcnt_q <= bcnt_q - 32'd1;
          end else begin
            st <= S_WAIT;
          end
        end
        S_WAIT: if (mem_valid) begin
          cache_q <= mem_data;
          cache_a <= baddr;
          cache_v <= 1'b1;
          st      <= S_TOP;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R4
  wr_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ep_q == $past(ep_q) + 1'b1);

  // R5
  step_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (bcnt_q == $past(bcnt_q) - 32'd1) && (bix_q == $past(bix_q) + 32'd1));

  // R6
  done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ep_q == '0 && !busy);

  // R7
  cc_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cc == 2'd2) |-> vcount_out == FULL);

  // R8
  intr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    interrupted |-> $stable(bix_q) && $stable(bcnt_q) && $stable(ep_q));

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_valid) |=> mem_req && $stable(mem_addr));

  // R10
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && interrupted));
endmodule

// File: tb/tb_setbit_scan.sv
module tb_setbit_scan;
  localparam int CLK_P  = 10;
  localparam int ADDR_W = 24;
  localparam int SECT   = 8;
  localparam int EW     = $clog2(SECT + 1);

  logic clk = 0, rst_n = 0, start = 0, intr_req = 0;
  logic [ADDR_W-1:0] base_addr = '0;
  logic [31:0] bix_in = '0, bcnt_in = '0;
  logic [EW-1:0] ep_in = '0;
  logic mem_req, mem_valid = 0, wr_en, done, interrupted, busy;
  logic [ADDR_W-1:0] mem_addr;
  logic [7:0] mem_data = '0;
  logic [EW-1:0] wr_elem, ep_out, vcount_out;
  logic [31:0] wr_value, bix_out, bcnt_out;
  logic [1:0] cc;

  setbit_scan #(.ADDR_W(ADDR_W), .SECT(SECT)) dut (.*);

  always #(CLK_P/2) clk = ~clk;

  int checks = 0, errors = 0;
  logic [7:0] mem [256];
  int lat = 0, reads = 0, wcnt = 0;
  logic [31:0] got [SECT];

  always @(posedge clk) begin
    mem_valid <= 1'b0;
    if (mem_req && !mem_valid) begin
      if (lat == 2) begin
        mem_valid <= 1'b1; mem_data <= mem[mem_addr[7:0]]; reads <= reads + 1; lat <= 0;
      end else lat <= lat + 1;
    end
    if (wr_en) begin
      if (int'(wr_elem) < SECT) got[wr_elem] <= wr_value;
      wcnt <= wcnt + 1;
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] fill_byte(input int mode, input int a);
    if (mode == 1) return 8'h00;
    if (mode == 2) return 8'h81;
    return 8'((a * 73 + 11) ^ (a >> 2));
  endfunction

  logic [31:0] e_bix, e_bcnt, e_val [SECT];
  int e_ep, e_vc, e_cc, e_reads, e_wr;

  task automatic model(input logic [ADDR_W-1:0] b, input logic [31:0] x, input logic [31:0] n, input int p);
    logic [ADDR_W-1:0] prev = '0, a;
    logic [31:0] sx;
    bit have = 0;
    e_reads = 0; e_wr = 0; e_bix = x; e_bcnt = n; e_ep = p;
    while (e_ep != SECT && $signed(e_bcnt) > 0) begin
      sx = {{3{e_bix[31]}}, e_bix[31:3]};
      a = b + sx[ADDR_W-1:0];
      if (!have || a != prev) e_reads++;
      have = 1; prev = a;
      if (mem[a[7:0]][7 - int'(e_bix[2:0])]) begin
        e_val[e_ep] = e_bix; e_ep++; e_wr++;
      end
      e_bix = e_bix + 1; e_bcnt = e_bcnt - 1;
    end
    e_vc = e_ep;
    if (e_vc == 0) e_cc = (e_bcnt == 0) ? 0 : 1;
    else if (e_vc == SECT && $signed(e_bcnt) > 0) e_cc = 2;
    else e_cc = 3;
    e_ep = 0;
  endtask

  task automatic launch(input logic [ADDR_W-1:0] b, input logic [31:0] x, input logic [31:0] n, input int p);
    @(negedge clk);
    base_addr = b; bix_in = x; bcnt_in = n; ep_in = EW'(p); start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic wait_end;
    int t = 0;
    while (!(done || interrupted) && t < 3000) begin @(negedge clk); t++; end
    if (t >= 3000) chk("R10", "watchdog", 32'd1, 32'd0);
  endtask

  task automatic check_result(input string tag);
    chk("R5", {tag, " bix"}, bix_out, e_bix);
    chk("R5", {tag, " bcnt"}, bcnt_out, e_bcnt);
    chk("R6", {tag, " ep cleared"}, 32'(ep_out), 32'(e_ep));
    chk("R6", {tag, " vcount"}, 32'(vcount_out), 32'(e_vc));
    chk("R7", {tag, " cc"}, 32'(cc), 32'(e_cc));
    chk("R4", {tag, " writes"}, 32'(wcnt), 32'(e_wr));
    for (int i = 0; i < e_wr && i < SECT; i++) chk("R3", {tag, " element"}, got[i], e_val[i]);
  endtask

  // base(24) bix(32) bcnt(32) ep(8) fill(8)
  localparam logic [103:0] VEC [8] = '{
    {24'h000010, 32'd0,        32'd40,         8'd0, 8'd0},
    {24'h000040, 32'hFFFFFFEC, 32'd30,         8'd0, 8'd0},
    {24'h000020, 32'd0,        32'd64,         8'd0, 8'd1},
    {24'h000030, 32'd0,        32'd32,         8'd0, 8'd2},
    {24'h000030, 32'd5,        32'hFFFFFFFB,   8'd0, 8'd0},
    {24'h000030, 32'd3,        32'd0,          8'd3, 8'd0},
    {24'h000008, 32'h7FFFFFFE, 32'd4,          8'd2, 8'd0},
    {24'h000000, 32'd0,        32'd20,         8'd8, 8'd0}
  };

  initial begin
    int wd_dummy;
    wd_dummy = 0;
    repeat (3) @(negedge clk);
    // R1
    chk("R1", "done", 32'(done), 0);
    chk("R1", "interrupted", 32'(interrupted), 0);
    chk("R1", "busy", 32'(busy), 0);
    chk("R1", "mem_req", 32'(mem_req), 0);
    chk("R1", "wr_en", 32'(wr_en), 0);
    chk("R1", "outputs", bix_out | bcnt_out | 32'(ep_out) | 32'(vcount_out) | 32'(cc), 0);
    rst_n = 1;

    for (int v = 0; v < 8; v++) begin
      logic [103:0] e;
      e = VEC[v];
      for (int a = 0; a < 256; a++) mem[a] = fill_byte(int'(e[7:0]), a);
      model(e[103:80], e[79:48], e[47:16], int'(e[15:8]));
      @(negedge clk); reads = 0; wcnt = 0;
      launch(e[103:80], e[79:48], e[47:16], int'(e[15:8]));
      wait_end;
      check_result($sformatf("vec%0d", v));
      chk("R9", $sformatf("vec%0d reads", v), 32'(reads), 32'(e_reads));
      if ($signed(e[47:16]) <= 0) begin
        chk("R2", "no reads", 32'(reads), 0);
        chk("R2", "index kept", bix_out, e[79:48]);
      end
      @(negedge clk);
      chk("R10", "done one cycle", 32'(done), 0);
    end

    // R8: interrupt then resume
    begin
      logic [31:0] x0, n0, x1, n1;
      int p1;
      for (int a = 0; a < 256; a++) mem[a] = fill_byte(0, a);
      x0 = 32'd3; n0 = 32'd60;
      model(24'h50, x0, n0, 0);
      @(negedge clk); reads = 0; wcnt = 0;
      launch(24'h50, x0, n0, 0);
      repeat (20) @(negedge clk);
      intr_req = 1;
      wait_end;
      chk("R8", "interrupted", 32'(interrupted), 1);
      chk("R10", "no done with intr", 32'(done), 0);
      x1 = bix_out; n1 = bcnt_out; p1 = int'(ep_out);
      chk("R8", "index/count consistent", x1 - x0, n0 - n1);
      chk("R8", "ptr equals writes", 32'(p1), 32'(wcnt));
      @(negedge clk);
      intr_req = 0;
      launch(24'h50, x1, n1, p1);
      wait_end;
      check_result("R8 resumed");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    errors++; checks++;
    $display("FAIL R10 watchdog actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule